// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between an on-chip host and an external asynchronous static RAM of 32K words by 16 bits that has two separately enabled byte lanes. The host posts one request at a time through a valid/ready handshake: a word address, write data, a per-byte mask and a read/write flag. The controller turns each request into a glitch-free sequence of active-low memory strobes. Every strobe comes straight from a flip-flop, and the number of wait cycles follows from the clock period and the memory's timing figures.

Writes place the address and lane enables one cycle before the write strobe falls and hold them one cycle after it rises. Reads keep chip enable, output enable, address and lane enables steady long enough to meet the access time. The captured word is then returned with a one-cycle valid strobe, and bytes of lanes that were not requested read as zero. The bidirectional data bus is modelled as separate output, output-enable and input signals. The controller drives the bus only while a write is in progress, and it puts a dead cycle between a read and a following write. When no access is running the chip stays deselected, so it remains in its low-power state. A request with an empty byte mask completes without touching the memory.

Top module: `asram_lane_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all memory strobes (chip, write, output and both lane enables) are high, the bus driver is off, `rsp_valid` is low and `req_ready` is high.
- R2: A request is taken on the rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly in the cycles where no access or turnaround is pending.
- R3: For a write with a non-zero mask accepted at edge k (and no turnaround due), the cycles after edges k, k+1 .. k+WR, and k+WR+1 show a setup cycle, WR cycles of low write enable, and a hold cycle. In all of them chip enable is low, output enable is high, the address and lane enables are steady, and the write data is driven. WR = max(1, ceil(T_WP_PS / CLK_PS)).
- R4: For a read with a non-zero mask accepted at edge k, chip enable and output enable are low and write enable is high for the RD cycles after edges k .. k+RD-1, with a steady address. The data bus is sampled at edge k+RD. RD = max(1, ceil(T_AA_PS / CLK_PS)).
- R5: Mask bit 0 controls lane enable bit 0 and data bits 7:0. Mask bit 1 controls lane enable bit 1 and data bits 15:8. During an access each lane enable is the inverse of its mask bit, and only the selected bytes of a memory word are changed by a write.
- R6: `rsp_valid` is high for the single cycle after edge k+RD, where `rsp_rdata` holds the sampled bytes of the selected lanes. Bytes of unselected lanes are zero.
- R7: The bus driver enable is high only in the write setup, strobe and hold cycles. Output enable is never low while it is high, and write enable and output enable are never low together.
- R8: A write accepted in the first cycle after a read's last access cycle gets one extra cycle with every strobe high and the driver off before its setup cycle. Output enable therefore stays high for at least two cycles before the driver turns on.
- R9: A request whose mask is zero asserts no strobe and keeps `req_ready` high. For a read, `rsp_valid` pulses in the cycle after acceptance with `rsp_rdata` zero. For a write, memory contents are unchanged.
- R10: Whenever chip enable is high, write enable, output enable and both lane enables are high and the driver is off. Chip enable is high in every cycle with no access running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unselected bytes zero |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lane_n | output | 2 | Byte lane enables, active low, bit 0 = low byte |
| mem_addr | output | 15 | Memory word address |
| mem_dq_out | output | 16 | Data to the bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | 16 | Data from the bus |

## Verification
Each result has a fixed cycle. A write's setup cycle follows the accepting edge directly, or one cycle later after a read. Its strobe lasts WR cycles, and then comes a single hold cycle. Read data is sampled RD edges after acceptance and is reported in the next cycle. A zero-mask read answers in the cycle right after acceptance. The bench turns every accepted request into a queue of expected per-cycle pin states built from these counts and compares all strobes, the address, the data and the handshake once per clock at the falling edge, away from the edge where the design updates. Its memory model returns valid data only after the strobes and address have been steady for the access time, and it puts a fill pattern on lanes that were not selected. Late sampling and missing lane zeroing both show up in the returned words.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RACC
  } ctl_state_e;

  // Cycles needed to cover a timing figure, never fewer than one.
  function automatic int wait_cycles(input int need_ps, input int clk_ps);
    int n;
    n = (need_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/asram_wait_ctr.sv
module asram_wait_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load || (step && (cnt_q != '0));
    if (load) begin
      cnt_d = load_val;
    end else if (step && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_req_hold.sv
module asram_req_hold #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [LANES-1:0]  cap_mask,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam int LW = DATA_W / LANES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= cap_en;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] byte_d;

    always_comb begin
      byte_d = cap_mask[g] ? bus_in[g*LW +: LW] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata[g*LW +: LW] <= '0;
      end else if (cap_en) begin
        rdata[g*LW +: LW] <= byte_d;
      end
    end
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int CLK_PS  = 5000,
  parameter int T_AA_PS = 10000,
  parameter int T_WP_PS = 7000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_mask,
  input  logic [LANES-1:0] mask_q,
  output logic             ready,
  output logic             accept,
  output logic             cap_en,
  output logic [LANES-1:0] cap_mask,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [LANES-1:0] lane_n,
  output logic             dq_oe
);

  localparam int RD_CYC = wait_cycles(T_AA_PS, CLK_PS);
  localparam int WR_CYC = wait_cycles(T_WP_PS, CLK_PS);
  localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CW = ($clog2(MAX_CYC) < 1) ? 1 : $clog2(MAX_CYC);

  ctl_state_e       state_q, state_d;
  logic             rd_last_q;
  logic             ctr_load, ctr_step, ctr_done;
  logic [CW-1:0]    ctr_val;
  logic [LANES-1:0] mask_d;
  logic             busy_d, drive_d;

  asram_wait_ctr #(.CW(CW)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_val (ctr_val),
    .step     (ctr_step),
    .done     (ctr_done)
  );

  assign ready  = (state_q == ST_IDLE);
  assign accept = ready && req_valid;
  assign mask_d = accept ? req_mask : mask_q;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    ctr_load = 1'b0;
    ctr_step = 1'b0;
    ctr_val  = '0;
    cap_en   = 1'b0;
    cap_mask = mask_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_mask == '0) begin
            cap_en   = !req_write;
            cap_mask = '0;
          end else if (req_write) begin
            state_d = rd_last_q ? ST_TURN : ST_WSET;
          end else begin
            state_d  = ST_RACC;
            ctr_load = 1'b1;
            ctr_val  = CW'(RD_CYC - 1);
          end
        end
      end
      ST_TURN: state_d = ST_WSET;
      ST_WSET: begin
        state_d  = ST_WPUL;
        ctr_load = 1'b1;
        ctr_val  = CW'(WR_CYC - 1);
      end
      ST_WPUL: begin
        if (ctr_done) state_d = ST_WHLD;
        else          ctr_step = 1'b1;
      end
      ST_WHLD: state_d = ST_IDLE;
      ST_RACC: begin
        if (ctr_done) begin
          state_d = ST_IDLE;
          cap_en  = 1'b1;
        end else begin
          ctr_step = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Strobe values for the coming cycle, decoded from the next state
  always_comb begin
    busy_d  = (state_d == ST_WSET) || (state_d == ST_WPUL) ||
              (state_d == ST_WHLD) || (state_d == ST_RACC);
    drive_d = (state_d == ST_WSET) || (state_d == ST_WPUL) ||
              (state_d == ST_WHLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rd_last_q <= 1'b0;
      ce_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      lane_n    <= '1;
      dq_oe     <= 1'b0;
    end else begin
      state_q   <= state_d;
      rd_last_q <= (state_q == ST_RACC);
      ce_n      <= !busy_d;
      we_n      <= (state_d != ST_WPUL);
      oe_n      <= (state_d != ST_RACC);
      lane_n    <= busy_d ? ~mask_d : '1;
      dq_oe     <= drive_d;
    end
  end

endmodule

// File: rtl/asram_lane_ctrl.sv
module asram_lane_ctrl #(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 16,
  parameter int CLK_PS  = 5000,
  parameter int T_AA_PS = 10000,
  parameter int T_WP_PS = 7000,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  logic             accept;
  logic             cap_en;
  logic [LANES-1:0] cap_mask;
  logic [LANES-1:0] mask_q;

  asram_req_hold #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .mask_q    (mask_q)
  );

  asram_seq #(
    .LANES   (LANES),
    .CLK_PS  (CLK_PS),
    .T_AA_PS (T_AA_PS),
    .T_WP_PS (T_WP_PS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_mask  (req_mask),
    .mask_q    (mask_q),
    .ready     (req_ready),
    .accept    (accept),
    .cap_en    (cap_en),
    .cap_mask  (cap_mask),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .lane_n    (mem_lane_n),
    .dq_oe     (mem_dq_oe)
  );

  asram_rd_capture #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_mask (cap_mask),
    .bus_in   (mem_dq_in),
    .rdata    (rsp_rdata),
    .rvalid   (rsp_valid)
  );

endmodule

// File: rtl/asram_lane_ctrl_chk.sv
module asram_lane_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_lane_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);

  a_r7_no_drive_while_oe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r7_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  a_r8_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (mem_oe_n && $past(mem_oe_n) && $past(mem_oe_n, 2)));

  a_r3_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr) && $stable(mem_lane_n)));

  a_r3_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_lane_n)));

  a_r4_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  a_r9_no_empty_access: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (mem_lane_n != '1));

  a_r10_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe && (mem_lane_n == '1)));

  a_r2_ready_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

  a_r6_rsp_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mem_ce_n);

endmodule

bind asram_lane_ctrl asram_lane_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_lane_n (mem_lane_n),
  .mem_addr   (mem_addr),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_asram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_asram_lane_ctrl;

  localparam int CLK_NS = 5;
  localparam int CLK_PS = CLK_NS * 1000;
  localparam int TAA_PS = 10000;
  localparam int TWP_PS = 7000;
  localparam int RD_N   = ((TAA_PS + CLK_PS - 1) / CLK_PS < 1) ? 1 : (TAA_PS + CLK_PS - 1) / CLK_PS;
  localparam int WR_N   = ((TWP_PS + CLK_PS - 1) / CLK_PS < 1) ? 1 : (TWP_PS + CLK_PS - 1) / CLK_PS;
  localparam int WDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [14:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'h5AA5;

  always #(CLK_NS * 0.5) clk = ~clk;

  asram_lane_ctrl #(
    .ADDR_W (15), .DATA_W (16), .CLK_PS (CLK_PS), .T_AA_PS (TAA_PS), .T_WP_PS (TWP_PS)
  ) dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata), .req_mask (req_mask),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .mem_ce_n (mem_ce_n), .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n),
    .mem_lane_n (mem_lane_n), .mem_addr (mem_addr), .mem_dq_out (mem_dq_out),
    .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- memory model (behavioural) ----------------
  bit [15:0] sram [int];
  logic [21:0] sig_prev = '0;
  int stab = 0;

  function automatic bit [15:0] sram_get(input int a);
    return sram.exists(a) ? sram[a] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    logic [21:0] sig_now;
    logic        rd_cond;
    bit [15:0]   w;
    sig_now = {mem_ce_n, mem_oe_n, mem_we_n, mem_lane_n, 2'b00, mem_addr};
    if (sig_now == sig_prev) stab++;
    else stab = 0;
    sig_prev = sig_now;
    if (!mem_ce_n && !mem_we_n) begin
      w = sram_get(int'(mem_addr));
      for (int i = 0; i < 2; i++)
        if (!mem_lane_n[i]) w[i*8 +: 8] = mem_dq_out[i*8 +: 8];
      sram[int'(mem_addr)] = w;
    end
    rd_cond = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (rd_cond && ((stab + 1) * CLK_PS >= TAA_PS)) begin
      w = sram_get(int'(mem_addr));
      for (int i = 0; i < 2; i++)
        mem_dq_in[i*8 +: 8] = mem_lane_n[i] ? 8'hC3 : w[i*8 +: 8];
    end else begin
      mem_dq_in = 16'h5AA5;
    end
  end

  // ---------------- reference model: expected pins per cycle ----------------
  typedef struct packed {
    logic        ce_n, we_n, oe_n;
    logic [1:0]  lane_n;
    logic        dq_oe, ready, rsp;
    logic [14:0] addr;
    logic [15:0] dout;
    logic [15:0] rdata;
    logic [2:0]  kind;   // 0 idle, 1 turn, 2 write, 3 read, 4 read rsp, 5 empty-mask rsp
  } exp_t;

  exp_t exp_q[$];
  bit [15:0] ref_mem [int];
  bit mon_on = 1'b0;

  function automatic exp_t idle_v();
    exp_t e;
    e = '0;
    e.ce_n = 1'b1; e.we_n = 1'b1; e.oe_n = 1'b1; e.lane_n = 2'b11; e.ready = 1'b1;
    return e;
  endfunction

  function automatic string kind_tag(input logic [2:0] k);
    case (k)
      3'd1: return "R8";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(negedge clk) begin
    exp_t e, v;
    bit   after_rd;
    bit [15:0] rw;
    if (mon_on) begin
      e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_v();
      check(kind_tag(e.kind), "ce_n", 32'(mem_ce_n), 32'(e.ce_n));
      check(kind_tag(e.kind), "we_n", 32'(mem_we_n), 32'(e.we_n));
      check(kind_tag(e.kind), "oe_n", 32'(mem_oe_n), 32'(e.oe_n));
      check("R5", "lane_n", 32'(mem_lane_n), 32'(e.lane_n));
      check("R7", "dq_oe", 32'(mem_dq_oe), 32'(e.dq_oe));
      check("R2", "req_ready", 32'(req_ready), 32'(e.ready));
      check(kind_tag(e.kind), "rsp_valid", 32'(rsp_valid), 32'(e.rsp));
      if (!e.ce_n) check(kind_tag(e.kind), "addr", 32'(mem_addr), 32'(e.addr));
      if (e.dq_oe) check("R3", "dq_out", 32'(mem_dq_out), 32'(e.dout));
      if (e.rsp) check(kind_tag(e.kind), "rdata", 32'(rsp_rdata), 32'(e.rdata));
      after_rd = (e.kind == 3'd4);
      if (req_valid && req_ready) begin
        if (req_mask == 2'b00) begin
          if (!req_write) begin
            v = idle_v(); v.rsp = 1'b1; v.rdata = '0; v.kind = 3'd5;
            exp_q.push_back(v);
          end
        end else if (req_write) begin
          if (after_rd) begin
            v = idle_v(); v.ready = 1'b0; v.kind = 3'd1;
            exp_q.push_back(v);
          end
          v = '0; v.ce_n = 1'b0; v.we_n = 1'b1; v.oe_n = 1'b1; v.lane_n = ~req_mask;
          v.dq_oe = 1'b1; v.addr = req_addr; v.dout = req_wdata; v.kind = 3'd2;
          exp_q.push_back(v);
          v.we_n = 1'b0;
          for (int i = 0; i < WR_N; i++) exp_q.push_back(v);
          v.we_n = 1'b1;
          exp_q.push_back(v);
          rw = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 16'h0000;
          for (int i = 0; i < 2; i++)
            if (req_mask[i]) rw[i*8 +: 8] = req_wdata[i*8 +: 8];
          ref_mem[int'(req_addr)] = rw;
        end else begin
          v = '0; v.ce_n = 1'b0; v.we_n = 1'b1; v.oe_n = 1'b0; v.lane_n = ~req_mask;
          v.addr = req_addr; v.kind = 3'd3;
          for (int i = 0; i < RD_N; i++) exp_q.push_back(v);
          rw = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 16'h0000;
          v = idle_v(); v.rsp = 1'b1; v.kind = 3'd4;
          v.rdata = {req_mask[1] ? rw[15:8] : 8'h00, req_mask[0] ? rw[7:0] : 8'h00};
          exp_q.push_back(v);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit w, input logic [14:0] a, input logic [15:0] d, input logic [1:0] m);
    req_write = w; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    // R1: reset state, during and after reset
    @(negedge clk);
    check("R1", "ce_n in reset", 32'(mem_ce_n), 32'd1);
    check("R1", "we_n in reset", 32'(mem_we_n), 32'd1);
    check("R1", "oe_n in reset", 32'(mem_oe_n), 32'd1);
    check("R1", "lane_n in reset", 32'(mem_lane_n), 32'h3);
    check("R1", "dq_oe in reset", 32'(mem_dq_oe), 32'd0);
    check("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    check("R1", "req_ready in reset", 32'(req_ready), 32'd1);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    mon_on = 1'b1;
    gap(3);

    // R3, R4, R5: full-word write and readback
    issue(1'b1, 15'h0001, 16'h1234, 2'b11);
    gap(2);
    issue(1'b0, 15'h0001, 16'h0000, 2'b11);
    // R8: write right after the read
    issue(1'b1, 15'h0002, 16'hABCD, 2'b01);
    issue(1'b0, 15'h0002, 16'h0000, 2'b11);   // R5: 00CD
    issue(1'b1, 15'h0002, 16'h77EE, 2'b10);
    issue(1'b0, 15'h0002, 16'h0000, 2'b10);   // R6: 7700
    issue(1'b0, 15'h0002, 16'h0000, 2'b01);   // R6: 00CD
    issue(1'b0, 15'h0002, 16'h0000, 2'b11);   // 77CD
    // R9: empty-mask write leaves memory alone, empty-mask reads answer zero
    issue(1'b1, 15'h0001, 16'hFFFF, 2'b00);
    issue(1'b0, 15'h0001, 16'h0000, 2'b00);
    issue(1'b0, 15'h0001, 16'h0000, 2'b00);
    issue(1'b0, 15'h0001, 16'h0000, 2'b11);
    // boundaries of the address range
    issue(1'b1, 15'h7FFF, 16'hC0DE, 2'b11);
    issue(1'b1, 15'h0000, 16'hBEEF, 2'b11);
    issue(1'b0, 15'h7FFF, 16'h0000, 2'b11);
    issue(1'b0, 15'h0000, 16'h0000, 2'b11);
    gap(4);

    // mixed traffic on a small address window, with and without gaps
    for (int n = 0; n < 400; n++) begin
      issue(1'($urandom_range(0, 1)), 15'($urandom_range(0, 15)),
            16'($urandom), 2'($urandom_range(0, 3)));
      if ($urandom_range(0, 3) == 0) gap($urandom_range(1, 3));
    end

    gap(RD_N + WR_N + 8);
    check("R2", "expected queue drained", 32'(exp_q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule